// File: doc/BRIEF.md
# Multicycle 8-bit Microcoded Processor

This block is a tiny 8-bit processor with a bank of eight byte-wide registers. Register 7 is the program counter. Registers 5 and 6 hold the low and high bytes of the 16-bit instruction being run. Every instruction takes five clock cycles, paced by a phase counter. In four of those cycles the phase counter injects fixed internal operations. Two are loads that fetch the instruction bytes into registers 5 and 6. The other two are add-immediates of one to the program counter. The fifth cycle runs the fetched instruction. Fetch therefore reuses the same datapath as a program's own loads and adds, with no separate fetch engine.

The datapath has a two-read, one-write register file, an adder that can also produce zero, a result selector that picks either the adder or memory, and a small memory. Byte addresses with the upper nibble clear read a 16-byte program ROM, whose contents come from a parameter. All other addresses reach a RAM indexed by its low address bits. Debug outputs expose every register and the current phase. The default ROM image runs a loop that reads a counter from RAM address 0x80, adds one, stores it back and jumps back by eight.

Top module: `cpu8_core`

## Requirements
- R1: An asynchronous active-low reset clears all eight registers, the phase and every RAM byte to zero at once.
- R2: The phase steps 0,1,2,3,4 and then back to 0, advancing one step per rising clock edge.
- R3: In phase 0, register 5 is loaded from memory at the program counter. In phase 2, register 6 is loaded the same way. In phases 1 and 3, the program counter increases by one.
- R4: In the execute phase, the low instruction byte decodes as: bit 0 memory access, bit 1 immediate, bit 2 write memory, bits 4:3 function, bits 7:5 destination index. When the immediate bit is set, operand A is the whole high byte and operand D is the destination register.
- R5: Function code 0 yields A + D modulo 256, with the carry dropped. Function codes 1, 2 and 3 yield zero.
- R6: When the immediate bit is clear, A is the register selected by high-byte bits 2:0 and D is the register selected by high-byte bits 5:3.
- R7: When the memory bit is set and the write-memory bit is clear, the destination register is loaded with the byte at the address held in the register selected by bits 2:0. Addresses 0x00 to 0x0F read the ROM.
- R8: When both the memory bit and the write-memory bit are set, the D register is written to the address held in A's register, and no register changes in that cycle.
- R9: Addresses with a nonzero upper nibble read and write the RAM using their low address bits, independent of the ROM bytes.
- R10: With the default image, register 0 holds the number of completed loop passes. That number rises by one every 20 cycles, starting with the third instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_phase | output | 3 | Current phase, 0 to 4 |
| dbg_regs | output | 64 | All registers; register i at bits 8i+7:8i |

## Verification
The bench goes after the decode corners. One case is an immediate add into a nonzero destination: a design that took D from the high-byte field would get the wrong sum. Other cases are a register add that overflows, which a design keeping the carry would get wrong, and a nonzero function code, which must clear the destination. A store is checked to alter no register, since a design that kept the register write enabled would corrupt register 0. A store to RAM at 0x93 is read back and compared with ROM byte 3, which would expose an address decode that let the RAM alias the ROM. A mid-run reset followed by a rerun of the counting loop exposes a RAM that is not cleared, because the count would resume from its old value. A wrong fetch or program-counter step shows up at every phase of the sweep as wrong instruction bytes or program-counter values.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 8;
  localparam int RIDX_W = 3;
  localparam int FN_W   = 2;

  localparam logic [RIDX_W-1:0] IDX_INS_LO = 3'd5;
  localparam logic [RIDX_W-1:0] IDX_INS_HI = 3'd6;
  localparam logic [RIDX_W-1:0] IDX_PC     = 3'd7;
  localparam logic [FN_W-1:0]   FN_ADD     = 2'd0;

  typedef enum logic [2:0] {
    PH_FETCH_LO = 3'd0,
    PH_BUMP_LO  = 3'd1,
    PH_FETCH_HI = 3'd2,
    PH_BUMP_HI  = 3'd3,
    PH_EXEC     = 3'd4
  } phase_e;

  typedef struct packed {
    logic              is_mem;
    logic              use_imm;
    logic              wr_mem;
    logic [FN_W-1:0]   fn;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] sa;
    logic [RIDX_W-1:0] sd;
    logic [DW-1:0]     imm;
  } ctl_t;
endpackage

// File: rtl/cpu8_seq.sv
module cpu8_seq
  import cpu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= PH_FETCH_LO;
    else if (phase == PH_EXEC) phase <= PH_FETCH_LO;
    else                     phase <= phase_e'(phase + 3'd1);
  end

  // R2
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_EXEC);
  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC) |=> (phase == PH_FETCH_LO));
  // R2
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_EXEC) |=> (phase != PH_FETCH_LO));
endmodule

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
(
  input  phase_e        phase,
  input  logic [DW-1:0] ins_lo,
  input  logic [DW-1:0] ins_hi,
  output ctl_t          ctl
);
  // injected fetch operations: byte load through the PC, or PC += 1
  function automatic ctl_t micro_op(input logic is_load, input logic [RIDX_W-1:0] dst);
    ctl_t c;
    c.is_mem  = is_load;
    c.use_imm = !is_load;
    c.wr_mem  = 1'b0;
    c.fn      = FN_ADD;
    c.dst     = dst;
    c.sa      = IDX_PC;
    c.sd      = dst;
    c.imm     = DW'(1);
    return c;
  endfunction

  always_comb begin
    case (phase)
      PH_FETCH_LO: ctl = micro_op(1'b1, IDX_INS_LO);
      PH_BUMP_LO:  ctl = micro_op(1'b0, IDX_PC);
      PH_FETCH_HI: ctl = micro_op(1'b1, IDX_INS_HI);
      PH_BUMP_HI:  ctl = micro_op(1'b0, IDX_PC);
      default: begin
        ctl.is_mem  = ins_lo[0];
        ctl.use_imm = ins_lo[1];
        ctl.wr_mem  = ins_lo[2];
        ctl.fn      = ins_lo[4:3];
        ctl.dst     = ins_lo[7:5];
        ctl.sa      = ins_hi[2:0];
        ctl.sd      = ins_lo[1] ? ins_lo[7:5] : ins_hi[5:3];
        ctl.imm     = ins_hi;
      end
    endcase
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int NR = 8,
  parameter int W  = 8,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_d,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_d,
  output logic [NR*W-1:0] dbg
);
  logic [W-1:0] q [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) q[i] <= '0;
    end else if (we) begin
      q[wa] <= wd;
    end
  end

  assign rd_a = q[ra_a];
  assign rd_d = q[ra_d];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    assign dbg[g*W +: W] = q[g];

    // R3
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(wa) == g) |=> (q[g] == $past(wd)));
    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && int'(wa) == g) |=> $stable(q[g]));
  end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   d,
  output logic [DW-1:0]   res
);
  logic [DW-1:0] sum;
  assign sum = a + d;
  assign res = (fn == FN_ADD) ? sum : '0;
endmodule

// File: rtl/cpu8_mem.sv
module cpu8_mem
  import cpu8_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  parameter int RAM_AW    = 4,
  parameter logic [ROM_DEPTH*DW-1:0] ROM_IMAGE = '0,
  localparam int ROM_AW    = $clog2(ROM_DEPTH),
  localparam int RAM_DEPTH = 1 << RAM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [RAM_DEPTH];
  logic          in_rom;
  logic [DW-1:0] rom_byte;

  assign in_rom   = (addr[DW-1:ROM_AW] == '0);
  assign rom_byte = ROM_IMAGE[int'(addr[ROM_AW-1:0]) * DW +: DW];
  assign rdata    = in_rom ? rom_byte : ram[addr[RAM_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else if (we && !in_rom) begin
      ram[addr[RAM_AW-1:0]] <= wdata;
    end
  end

  // R9
  ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !in_rom) |=> (ram[$past(addr[RAM_AW-1:0])] == $past(wdata)));
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  parameter int RAM_AW    = 4,
  parameter logic [ROM_DEPTH*DW-1:0] ROM_IMAGE = 128'h0000_0000_0000_f8e2_0105_0102_0101_8022
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [2:0]       dbg_phase,
  output logic [NREG*DW-1:0] dbg_regs
);
  phase_e        phase;
  ctl_t          ctl;
  logic [DW-1:0] rd_a, rd_d, op_a, alu_res, mem_rdata, reg_wd;
  logic          store;

  cpu8_seq u_seq (.clk(clk), .rst_n(rst_n), .phase(phase));

  cpu8_decode u_dec (
    .phase (phase),
    .ins_lo(dbg_regs[int'(IDX_INS_LO)*DW +: DW]),
    .ins_hi(dbg_regs[int'(IDX_INS_HI)*DW +: DW]),
    .ctl   (ctl)
  );

  assign store  = ctl.is_mem & ctl.wr_mem;
  assign op_a   = ctl.use_imm ? ctl.imm : rd_a;
  assign reg_wd = ctl.is_mem ? mem_rdata : alu_res;

  cpu8_regfile #(.NR(NREG), .W(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(ctl.sa), .ra_d(ctl.sd),
    .we(!store), .wa(ctl.dst), .wd(reg_wd),
    .rd_a(rd_a), .rd_d(rd_d), .dbg(dbg_regs)
  );

  cpu8_alu u_alu (.fn(ctl.fn), .a(op_a), .d(rd_d), .res(alu_res));

  cpu8_mem #(.ROM_DEPTH(ROM_DEPTH), .RAM_AW(RAM_AW), .ROM_IMAGE(ROM_IMAGE)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .addr(rd_a), .we(store), .wdata(rd_d), .rdata(mem_rdata)
  );

  assign dbg_phase = phase;

  // R3
  pc_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUMP_LO || phase == PH_BUMP_HI) |=>
      (dbg_regs[int'(IDX_PC)*DW +: DW] == $past(dbg_regs[int'(IDX_PC)*DW +: DW]) + 8'd1));
  // R8
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && ctl.is_mem && ctl.wr_mem) |=> $stable(dbg_regs));
  // R5
  alu_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fn != FN_ADD) |-> (alu_res == '0));
  // R4
  imm_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.use_imm |-> (ctl.sd == ctl.dst));
endmodule

// File: tb/sim_cpu8_core.sv
`timescale 1ns/1ps
module sim_cpu8_core;
  localparam logic [127:0] IMG0 = 128'h0000_0000_0000_f8e2_0105_0102_0101_8022;
  localparam logic [127:0] IMG1 = 128'h0141_2105_9322_0301_335a_1280_0142_fe42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ph0, ph1;
  logic [63:0] rg0, rg1;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu8_core u0 (.clk(clk), .rst_n(rst_n), .dbg_phase(ph0), .dbg_regs(rg0));
  cpu8_core #(.ROM_IMAGE(IMG1)) u1 (.clk(clk), .rst_n(rst_n), .dbg_phase(ph1), .dbg_regs(rg1));

  function automatic logic [7:0] rsel(logic [63:0] v, int i);
    return v[8*i +: 8];
  endfunction

  function automatic logic [7:0] exp_pc(int m);
    if (m == 0) return 8'd0;
    return 8'(2 + 2 * ((m - 1) % 4));
  endfunction

  function automatic logic [7:0] exp_cnt(int n);
    return (n >= 3) ? 8'((n - 3) / 4 + 1) : 8'd0;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);      // leaves a nonzero count in RAM
    #2 rst_n = 1'b0;                 // asynchronous, away from any edge
    #1;
    for (int i = 0; i < 8; i++) begin
      chk("R1 reset u0 reg", rsel(rg0, i), 8'h00);
      chk("R1 reset u1 reg", rsel(rg1, i), 8'h00);
    end
    chk("R1 reset phase", {5'd0, ph0}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 130; e++) begin
      @(negedge clk);
      chk("R2 phase", {5'd0, ph0}, 8'(e % 5));
      case (e % 5)
        0: begin
          chk("R3 pc at boundary", rsel(rg0, 7), exp_pc(e / 5));
          // R10 count also proves RAM was cleared by reset (R1)
          chk("R10 loop count", rsel(rg0, 0), exp_cnt(e / 5));
          chk("R4 immediate base", rsel(rg0, 1), (e >= 5) ? 8'h80 : 8'h00);
        end
        1: chk("R3 low byte fetch", rsel(rg0, 5), IMG0[8*exp_pc(e / 5) +: 8]);
        2: chk("R3 pc bump", rsel(rg0, 7), exp_pc(e / 5) + 8'd1);
        3: chk("R3 high byte fetch", rsel(rg0, 6), IMG0[8*(exp_pc(e / 5) + 1) +: 8]);
        default: ;
      endcase
      case (e)
        5:  chk("R4 imm load r2", rsel(rg1, 2), 8'hfe);
        10: chk("R4 imm adds dest reg", rsel(rg1, 2), 8'hff);
        15: chk("R5 R6 reg add carry dropped", rsel(rg1, 4), 8'hfe);
        20: chk("R5 nonzero function gives zero", rsel(rg1, 2), 8'h00);
        25: chk("R7 load from ROM", rsel(rg1, 0), 8'h42);
        30: chk("R4 imm r1", rsel(rg1, 1), 8'h93);
        35: begin
          chk("R8 store keeps r0", rsel(rg1, 0), 8'h42);
          chk("R8 store keeps r1", rsel(rg1, 1), 8'h93);
          chk("R8 store keeps r2", rsel(rg1, 2), 8'h00);
          chk("R8 store keeps r4", rsel(rg1, 4), 8'hfe);
        end
        40: chk("R9 RAM readback", rsel(rg1, 2), 8'hfe);
        default: ;
      endcase
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule